// File: doc/BRIEF.md
# Clock Loss Reset Controller

This block watches a main clock from a free-running reference clock and decides when the main clock has been silent long enough that dynamic state in the datapath can no longer be trusted. When that happens it raises a datapath reset and a power-down flag, and it forces every down-converter channel into power-down. When the main clock runs again, it drops these outputs by itself. No software action is needed. Configuration storage is outside the reach of this reset. The only status kept here is a sticky loss record, and the reset never clears it.

A two-bit mode input selects the behaviour. In automatic mode the detector drives the outputs. In forced mode the block stays in power-down. In disabled mode the clock-loss reset never fires. Per-channel power-down requests pass through to per-channel enables. One exception applies: when the output ordering mode needs the channel that feeds resampler slot 0 to produce its block-complete marker, that channel's request is refused. All pins are plain control and status levels. There is no streaming interface and no back-pressure. The main clock must run below half the reference frequency, because each of its rising edges flips one flag that the reference domain samples.

Top module: `clkloss_rst_ctrl`

## Requirements
- R1: While `por_n` is low and after it rises, `pd_flag` and `loss_seen` read 0. `dp_rst` reads 1 from the start of power-on reset until the second main-clock rising edge after `por_n` rises.
- R2: In automatic mode (`mode` = 00), `pd_flag` rises once `loss_limit` consecutive reference cycles pass with no observed main-clock toggle. Toggles are observed after a two-stage synchronizer.
- R3: `dp_rst` is high whenever `pd_flag` is high. It is set asynchronously, so it asserts even while the main clock is stopped.
- R4: After a loss, `pd_flag` falls once 4 main-clock toggles are observed with no new `loss_limit` gap among them.
- R5: `dp_rst` falls on the second main-clock rising edge after `pd_flag` falls. The release is synchronous to the main clock.
- R6: In forced mode (`mode` = 01), `pd_flag` is 1 on the reference edge after the mode is applied and stays 1 while the mode holds.
- R7: In disabled mode (`mode` = 10 or 11), `pd_flag` is 0 and the detector is cleared, so no loss is declared however long the main clock stops.
- R8: `loss_seen` becomes 1 when a loss is declared and stays 1 until `clr_loss` is sampled high. A new loss in the same cycle as `clr_loss` wins. The datapath reset does not clear `loss_seen`.
- R9: `chan_pd[i]` is 1 when `pd_flag` is 1. Otherwise it follows `chan_pd_req[i]`.
- R10: When `out_order` is 1 or 2 and `pd_flag` is 0, `chan_pd[feed_sel]` is 0 whatever its request. For `out_order` 0 or 3 the request passes through.
- R11: `loss_limit` is programmable. A main-clock stop shorter than `loss_limit` reference cycles declares no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| main_clk | input | 1 | Monitored main clock |
| mode | input | 2 | 00 automatic, 01 forced power-down, 10/11 disabled |
| loss_limit | input | LIM_W (8) | Silent reference cycles that declare a loss |
| clr_loss | input | 1 | Write-one pulse clearing `loss_seen` |
| chan_pd_req | input | NCH (4) | Per-channel power-down requests |
| out_order | input | 2 | Output ordering mode |
| feed_sel | input | SEL_W (2) | Channel feeding resampler slot 0 |
| dp_rst | output | 1 | Datapath reset, main-clock release |
| pd_flag | output | 1 | Whole-device power-down flag (reference domain) |
| chan_pd | output | NCH (4) | Per-channel power-down enables |
| loss_seen | output | 1 | Sticky clock-loss record |

## Verification
The bench stops the main clock for spans just below and well above the loss limit. A design that counts from the wrong point, or that treats a short gap as a loss, would flip `pd_flag` one cycle early or late against the model. It also changes the mode while a loss is active and stops the clock in disabled mode. There a design that left stale counters would raise power-down, or fail to drop it. Releasing with the main clock stopped checks that `dp_rst` holds until two real main edges arrive, which a design using a reference-domain release would break. It also sweeps ordering modes against channel requests, and raises clear and loss together, where a clear-wins sticky bit would drop the record.

// File: rtl/clr_pkg.sv
package clr_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO  = 2'b00,
    MODE_FORCE = 2'b01,
    MODE_OFF_A = 2'b10,
    MODE_OFF_B = 2'b11
  } clr_mode_e;
endpackage

// File: rtl/clr_toggle_src.sv
// Flips a flag on every main-clock rising edge; the reference side
// watches the flag for activity.
module clr_toggle_src (
  input  logic main_clk,
  input  logic por_n,
  output logic tgl
);
  always_ff @(posedge main_clk or negedge por_n) begin
    if (!por_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end
endmodule

// File: rtl/clr_activity_mon.sv
// Reference-domain detector: synchronizes the toggle flag, counts silent
// cycles, requires a run of toggles to recover, and keeps a sticky record.
module clr_activity_mon
  import clr_pkg::*;
#(
  parameter int LIM_W       = 8,
  parameter int RECOVER     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             por_n,
  input  logic             tgl_async,
  input  logic [1:0]       mode,
  input  logic [LIM_W-1:0] loss_limit,
  input  logic             clr_loss,
  output logic             pd_flag,
  output logic             loss_seen
);
  localparam int GOOD_W = $clog2(RECOVER + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   seen;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge ref_clk or negedge por_n) begin
          if (!por_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= tgl_async;
        end
      end else begin : g_rest
        always_ff @(posedge ref_clk or negedge por_n) begin
          if (!por_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign seen = sync_q[SYNC_STAGES-1] ^ prev_q;

  clr_mode_e  cur_mode;
  logic       off_mode;
  assign cur_mode = clr_mode_e'(mode);
  assign off_mode = (cur_mode == MODE_OFF_A) || (cur_mode == MODE_OFF_B);

  logic [LIM_W-1:0]  idle_q, idle_d;
  logic [LIM_W:0]    idle_inc;
  logic              gap_hit;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [GOOD_W:0]   good_inc;
  logic              good_done;
  logic              lost_q, lost_d;
  logic              enter_loss;
  logic              pd_d;
  logic              seen_d;

  assign idle_inc  = {1'b0, idle_q} + 1'b1;
  assign gap_hit   = idle_inc >= {1'b0, loss_limit};
  assign good_inc  = {1'b0, good_q} + 1'b1;
  assign good_done = good_inc >= (GOOD_W+1)'(RECOVER);

  always_comb begin
    idle_d     = idle_q;
    good_d     = good_q;
    lost_d     = lost_q;
    enter_loss = 1'b0;
    if (off_mode) begin
      idle_d = '0;
      good_d = '0;
      lost_d = 1'b0;
    end else if (!lost_q) begin
      if (seen) begin
        idle_d = '0;
      end else if (gap_hit) begin
        idle_d     = '0;
        good_d     = '0;
        lost_d     = 1'b1;
        enter_loss = 1'b1;
      end else begin
        idle_d = idle_inc[LIM_W-1:0];
      end
    end else begin
      if (seen) begin
        idle_d = '0;
        if (good_done) begin
          good_d = '0;
          lost_d = 1'b0;
        end else begin
          good_d = good_inc[GOOD_W-1:0];
        end
      end else if (gap_hit) begin
        idle_d = '0;
        good_d = '0;
      end else begin
        idle_d = idle_inc[LIM_W-1:0];
      end
    end
  end

  always_comb begin
    unique case (cur_mode)
      MODE_AUTO:  pd_d = lost_d;
      MODE_FORCE: pd_d = 1'b1;
      default:    pd_d = 1'b0;
    endcase
  end

  assign seen_d = enter_loss ? 1'b1 : (clr_loss ? 1'b0 : loss_seen);

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      idle_q    <= '0;
      good_q    <= '0;
      lost_q    <= 1'b0;
      pd_flag   <= 1'b0;
      loss_seen <= 1'b0;
    end else begin
      idle_q    <= idle_d;
      good_q    <= good_d;
      lost_q    <= lost_d;
      pd_flag   <= pd_d;
      loss_seen <= seen_d;
    end
  end
endmodule

// File: rtl/clr_rst_release.sv
// Reset that sets at once from any domain and clears only on main-clock edges.
module clr_rst_release #(
  parameter int STAGES = 2
) (
  input  logic main_clk,
  input  logic hold,
  output logic dp_rst
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge main_clk or posedge hold) begin
        if (hold) chain_q <= '1;
        else      chain_q <= '0;
      end
    end else begin : g_many
      always_ff @(posedge main_clk or posedge hold) begin
        if (hold) chain_q <= '1;
        else      chain_q <= {chain_q[STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign dp_rst = chain_q[STAGES-1];
endmodule

// File: rtl/clr_chan_gate.sv
// Per-channel power-down enables with protection of the resampler feeder.
module clr_chan_gate #(
  parameter int NCH   = 4,
  parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             dev_pd,
  input  logic [NCH-1:0]   chan_pd_req,
  input  logic [1:0]       out_order,
  input  logic [SEL_W-1:0] feed_sel,
  output logic [NCH-1:0]   chan_pd
);
  logic guard;
  assign guard = (out_order == 2'd1) || (out_order == 2'd2);

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      logic keep_on;
      assign keep_on    = guard && (feed_sel == SEL_W'(i));
      assign chan_pd[i] = dev_pd | (chan_pd_req[i] & ~keep_on);
    end
  endgenerate
endmodule

// File: rtl/clkloss_rst_ctrl.sv
module clkloss_rst_ctrl #(
  parameter int NCH         = 4,
  parameter int LIM_W       = 8,
  parameter int RECOVER     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int REL_STAGES  = 2,
  parameter int SEL_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             ref_clk,
  input  logic             por_n,
  input  logic             main_clk,
  input  logic [1:0]       mode,
  input  logic [LIM_W-1:0] loss_limit,
  input  logic             clr_loss,
  input  logic [NCH-1:0]   chan_pd_req,
  input  logic [1:0]       out_order,
  input  logic [SEL_W-1:0] feed_sel,
  output logic             dp_rst,
  output logic             pd_flag,
  output logic [NCH-1:0]   chan_pd,
  output logic             loss_seen
);
  logic tgl;
  logic hold;

  clr_toggle_src u_src (
    .main_clk (main_clk),
    .por_n    (por_n),
    .tgl      (tgl)
  );

  clr_activity_mon #(
    .LIM_W       (LIM_W),
    .RECOVER     (RECOVER),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .ref_clk    (ref_clk),
    .por_n      (por_n),
    .tgl_async  (tgl),
    .mode       (mode),
    .loss_limit (loss_limit),
    .clr_loss   (clr_loss),
    .pd_flag    (pd_flag),
    .loss_seen  (loss_seen)
  );

  assign hold = pd_flag | ~por_n;

  clr_rst_release #(.STAGES(REL_STAGES)) u_rel (
    .main_clk (main_clk),
    .hold     (hold),
    .dp_rst   (dp_rst)
  );

  clr_chan_gate #(.NCH(NCH), .SEL_W(SEL_W)) u_gate (
    .dev_pd      (pd_flag),
    .chan_pd_req (chan_pd_req),
    .out_order   (out_order),
    .feed_sel    (feed_sel),
    .chan_pd     (chan_pd)
  );
endmodule

// File: rtl/clkloss_rst_ctrl_chk.sv
module clkloss_rst_ctrl_chk #(
  parameter int NCH   = 4,
  parameter int SEL_W = 2
) (
  input logic             ref_clk,
  input logic             por_n,
  input logic [1:0]       mode,
  input logic             clr_loss,
  input logic [1:0]       out_order,
  input logic [SEL_W-1:0] feed_sel,
  input logic             pd_flag,
  input logic             dp_rst,
  input logic [NCH-1:0]   chan_pd,
  input logic             loss_seen
);
  AST_PD_HOLDS_DP_RST: assert property (@(posedge ref_clk) disable iff (!por_n)
    pd_flag |-> dp_rst); // R3

  AST_FORCE_MODE_PD: assert property (@(posedge ref_clk) disable iff (!por_n)
    (mode == 2'b01) |=> pd_flag); // R6

  AST_OFF_MODE_QUIET: assert property (@(posedge ref_clk) disable iff (!por_n)
    mode[1] |=> !pd_flag); // R7

  AST_LOSS_RECORD_STICKY: assert property (@(posedge ref_clk) disable iff (!por_n)
    (loss_seen && !clr_loss) |=> loss_seen); // R8

  AST_DEVICE_PD_ALL_CH: assert property (@(posedge ref_clk) disable iff (!por_n)
    pd_flag |-> (&chan_pd)); // R9

  AST_FEEDER_KEPT_ON: assert property (@(posedge ref_clk) disable iff (!por_n)
    (!pd_flag && (out_order == 2'd1 || out_order == 2'd2)) |-> !chan_pd[feed_sel]); // R10
endmodule

bind clkloss_rst_ctrl clkloss_rst_ctrl_chk #(.NCH(NCH), .SEL_W(SEL_W)) u_chk (
  .ref_clk   (ref_clk),
  .por_n     (por_n),
  .mode      (mode),
  .clr_loss  (clr_loss),
  .out_order (out_order),
  .feed_sel  (feed_sel),
  .pd_flag   (pd_flag),
  .dp_rst    (dp_rst),
  .chan_pd   (chan_pd),
  .loss_seen (loss_seen)
);

// File: tb/clkloss_rst_ctrl_test.sv
`timescale 1ns/1ps
module clkloss_rst_ctrl_test;
  localparam int NCH = 4;

  logic       ref_clk = 1'b0;
  logic       main_clk = 1'b0;
  logic       por_n = 1'b1;
  logic       main_run = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [7:0] loss_limit = 8'd16;
  logic       clr_loss = 1'b0;
  logic [3:0] chan_pd_req = 4'b0000;
  logic [1:0] out_order = 2'd0;
  logic [1:0] feed_sel = 2'd0;
  logic       dp_rst, pd_flag, loss_seen;
  logic [3:0] chan_pd;

  int vectors = 0;
  int errors  = 0;
  bit cmp_on  = 1'b0;

  clkloss_rst_ctrl uut (
    .ref_clk(ref_clk), .por_n(por_n), .main_clk(main_clk), .mode(mode),
    .loss_limit(loss_limit), .clr_loss(clr_loss), .chan_pd_req(chan_pd_req),
    .out_order(out_order), .feed_sel(feed_sel), .dp_rst(dp_rst),
    .pd_flag(pd_flag), .chan_pd(chan_pd), .loss_seen(loss_seen)
  );

  // 100 MHz reference: rising edges at 5,15,25,... (odd ns)
  initial forever #5 ref_clk = ~ref_clk;

  // Main clock, 26 ns period, rising edges only at 4+26k ns (even), gated
  initial begin
    #4;
    forever begin
      if (main_run) main_clk = 1'b1;
      #13;
      main_clk = 1'b0;
      #13;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic main_par;
  always @(posedge main_clk or negedge por_n)
    if (!por_n) main_par <= 1'b0;
    else        main_par <= ~main_par;

  bit  hist[$];
  bit  m_lost, m_sticky, m_pd;
  int  m_idle, m_good;
  int  pd_epoch = 0;
  int  seen_ep  = 0;
  int  rel      = 0;

  always @(posedge main_clk or negedge por_n) begin
    if (!por_n) begin
      rel = 0; seen_ep = pd_epoch;
    end else if (m_pd) begin
      rel = 0; seen_ep = pd_epoch;
    end else if (pd_epoch != seen_ep) begin
      rel = 1; seen_ep = pd_epoch;
    end else if (rel < 2) begin
      rel++;
    end
  end

  always @(posedge ref_clk) begin
    bit seen, enter;
    int lim;
    enter = 1'b0;
    lim = int'(loss_limit);
    if (!por_n) begin
      hist = '{0, 0, 0, 0};
      m_lost = 0; m_sticky = 0; m_idle = 0; m_good = 0; m_pd = 0;
    end else begin
      hist.push_back(main_par);
      if (hist.size() > 8) void'(hist.pop_front());
      seen = hist[hist.size()-3] ^ hist[hist.size()-4];
      if (mode[1]) begin
        m_lost = 0; m_idle = 0; m_good = 0;
      end else if (!m_lost) begin
        if (seen) m_idle = 0;
        else if (m_idle + 1 >= lim) begin
          m_lost = 1; m_idle = 0; m_good = 0; enter = 1;
        end else m_idle++;
      end else begin
        if (seen) begin
          m_idle = 0;
          if (m_good + 1 >= 4) begin m_lost = 0; m_good = 0; end
          else m_good++;
        end else if (m_idle + 1 >= lim) begin
          m_idle = 0; m_good = 0;
        end else m_idle++;
      end
      if (enter) m_sticky = 1;
      else if (clr_loss) m_sticky = 0;
      m_pd = (mode == 2'b01) || (mode == 2'b00 && m_lost);
    end
    if (m_pd) pd_epoch++;
    #2;
    if (cmp_on) begin
      logic [3:0] exp_ch;
      bit exp_dp;
      for (int i = 0; i < NCH; i++)
        exp_ch[i] = m_pd | (chan_pd_req[i] &
                    ~((out_order == 2'd1 || out_order == 2'd2) && feed_sel == 2'(i)));
      exp_dp = !por_n || m_pd || (pd_epoch != seen_ep) || (rel < 2);
      check("R2 pd_flag", {31'd0, pd_flag}, {31'd0, m_pd});
      check("R5 dp_rst", {31'd0, dp_rst}, {31'd0, exp_dp});
      check("R9 chan_pd", {28'd0, chan_pd}, {28'd0, exp_ch});
      check("R8 loss_seen", {31'd0, loss_seen}, {31'd0, m_sticky});
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic probe(input string tag, input logic [31:0] act, input logic [31:0] exp);
    #1 check(tag, act, exp);
  endtask

  initial begin
    #1 por_n = 1'b0;
    cmp_on = 1'b1;
    cyc(10);
    por_n = 1'b1;
    probe("R1 dp_rst after por", {31'd0, dp_rst}, 32'd1);
    probe("R1 pd_flag after por", {31'd0, pd_flag}, 32'd0);
    probe("R1 loss_seen after por", {31'd0, loss_seen}, 32'd0);
    cyc(40);
    probe("R1 dp_rst released", {31'd0, dp_rst}, 32'd0);

    // R2/R3: stop the main clock in automatic mode
    main_run = 1'b0;
    cyc(30);
    probe("R2 loss declared", {31'd0, pd_flag}, 32'd1);
    probe("R3 dp_rst without main clock", {31'd0, dp_rst}, 32'd1);
    probe("R8 loss recorded", {31'd0, loss_seen}, 32'd1);

    // R4/R5: restart
    main_run = 1'b1;
    cyc(35);
    probe("R4 recovered", {31'd0, pd_flag}, 32'd0);
    probe("R5 dp_rst released", {31'd0, dp_rst}, 32'd0);
    probe("R8 record survives reset", {31'd0, loss_seen}, 32'd1);
    clr_loss = 1'b1; cyc(1); clr_loss = 1'b0;
    probe("R8 write-one clears", {31'd0, loss_seen}, 32'd0);

    // R11: short stop under a larger limit, then exceed it
    loss_limit = 8'd40;
    cyc(10);
    main_run = 1'b0;
    cyc(25);
    probe("R11 short stop ignored", {31'd0, pd_flag}, 32'd0);
    cyc(25);
    probe("R11 long stop detected", {31'd0, pd_flag}, 32'd1);
    // release with mode change while main clock still stopped
    mode = 2'b10;
    cyc(4);
    probe("R7 off mode clears pd", {31'd0, pd_flag}, 32'd0);
    probe("R5 dp_rst held without main edges", {31'd0, dp_rst}, 32'd1);
    clr_loss = 1'b1; cyc(1); clr_loss = 1'b0;
    cyc(60);
    probe("R7 no loss when disabled", {31'd0, pd_flag}, 32'd0);
    probe("R7 no record when disabled", {31'd0, loss_seen}, 32'd0);
    mode = 2'b11;
    cyc(20);
    probe("R7 mode 11 quiet", {31'd0, pd_flag}, 32'd0);
    main_run = 1'b1;
    cyc(20);

    // R6: forced power-down with clock running
    mode = 2'b01;
    cyc(1);
    probe("R6 forced pd", {31'd0, pd_flag}, 32'd1);
    cyc(15);
    probe("R9 all channels down", {28'd0, chan_pd}, 32'hF);
    mode = 2'b00;
    loss_limit = 8'd16;
    cyc(20);

    // R9/R10: channel gating sweep
    for (int oo = 0; oo < 4; oo++) begin
      for (int fs = 0; fs < 4; fs++) begin
        out_order = 2'(oo);
        feed_sel = 2'(fs);
        chan_pd_req = 4'b1111;
        cyc(1);
        probe("R10 feeder guard", {28'd0, chan_pd},
              (oo == 1 || oo == 2) ? (32'hF & ~(32'd1 << fs)) : 32'hF);
        chan_pd_req = 4'b0101;
        cyc(1);
        probe("R9 request pass", {28'd0, chan_pd},
              (oo == 1 || oo == 2) ? (32'h5 & ~(32'd1 << fs)) : 32'h5);
      end
    end

    // R8: clear held while a loss is declared (set wins)
    clr_loss = 1'b1;
    main_run = 1'b0;
    cyc(30);
    clr_loss = 1'b0;
    main_run = 1'b1;
    cyc(40);

    // tight limit: normal toggle spacing trips limit 2
    loss_limit = 8'd2;
    cyc(40);
    loss_limit = 8'd16;
    cyc(40);

    cmp_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule